// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block gives software per-pin control over a set of pads grouped into banks, each bank holding several 8-pin ports. A pin is in one of two modes. In passthrough mode its pad follows a special-purpose function's output and output enable. In GPIO mode its pad follows an output value and an output enable that software writes. Each pin also has an input sample taken through a synchroniser, an irreversible lock, and an interrupt source. The interrupt source can be set to fire on a level, on one edge, or on either edge.

Software reaches the registers over a plain word-addressed read/write port. The address holds a bank, an alias flag, a register type and a port. Each alias address updates only the bits picked by a mask in the same write word, so one write can change selected pins of a port without a read-modify-write. Each bank drives one interrupt line, the OR of its enabled and pending pins.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous reset every pin is in passthrough mode, and every control, lock, enable, trigger and status bit is 0.
- R2: The word address is {bank, alias, type[2:0], port[1:0]}, with the port in the least significant bits. The type codes are 0 config, 1 output enable, 2 output value, 3 input value, 4 interrupt status, 5 interrupt enable, 6 trigger, 7 interrupt clear. read data is valid the cycle after a read strobe and holds until the next strobe. An alias address reads the same as its base address.
- R3: Pad outputs are registered. When a pin's mode bit (config bit n) is 1, the pad drives the output value bit with the output enable bit. When the mode bit is 0, the pad copies the special-purpose output and enable.
- R4: Config bits 15..8 are the per-pin lock bits. A base write can set them, no write can clear them, and only reset clears them.
- R5: While a pin's lock bit is set, writes to its mode, output enable and output value bits are ignored, and this includes alias writes. The lock value in force before a write decides whether that write is blocked.
- R6: Each pad input passes through two flops before it reaches the input value register (type 3) and the trigger logic. Writes to the input value and status registers change nothing.
- R7: When trigger bit n+8 is 0, the pin is level-triggered. Status is set while the synchronised pin equals trigger bit n (1 means high, 0 means low).
- R8: When trigger bit n+8 is 1 and bit n+16 is 0, the pin is edge-triggered: on a rising edge if bit n is 1, on a falling edge if it is 0.
- R9: When trigger bits n+8 and n+16 are both 1, both edges set status, whatever bit n holds.
- R10: Writing 1 to clear bit n clears status bit n, and writing 0 has no effect. If the trigger condition holds in the same cycle as the clear, the status bit stays set, so a persisting level re-asserts.
- R11: Status bits only set while the pin's enable bit is 1. The bank's interrupt line is the registered OR of status AND enable over the bank.
- R12: An alias write uses bits 15..8 as a per-pin mask and bits 7..0 as data, and changes only the masked bits of the low byte of the base register. On the clear register it clears the status bits where both mask and data are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (7) | Word address {bank, alias, type, port} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PINS (64) | Pad input levels |
| spio_out | input | NUM_PINS (64) | Special-purpose output values |
| spio_oe | input | NUM_PINS (64) | Special-purpose output enables |
| pad_out | output | NUM_PINS (64) | Registered pad output value |
| pad_oe | output | NUM_PINS (64) | Registered pad output enable |
| irq | output | NUM_BANKS (2) | Per-bank interrupt line |

## Verification
Two events can land in the same cycle: a software write to the clear register and a trigger condition on the same pin. The bench sets up this collision by holding a level-triggered pin at its active level while it writes a clear. It then reads status back and expects the bit still set. After the level is removed, a second clear must leave the bit at 0. The edge-triggered pins are checked against the opposite case: a clear with no new edge must leave their status at 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    RT_CFG = 3'd0,
    RT_OE  = 3'd1,
    RT_OUT = 3'd2,
    RT_IN  = 3'd3,
    RT_STS = 3'd4,
    RT_EN  = 3'd5,
    RT_LVL = 3'd6,
    RT_CLR = 3'd7
  } reg_type_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_wr,
  input  logic          alias_wr,
  input  reg_type_e     wtype,
  input  logic [3*PW-1:0] wdata,
  input  logic [PW-1:0] pin_s,
  output logic [PW-1:0] mode_q,
  output logic [PW-1:0] lock_q,
  output logic [PW-1:0] oe_q,
  output logic [PW-1:0] out_q,
  output logic [PW-1:0] en_q,
  output logic [PW-1:0] sts_q,
  output logic [3*PW-1:0] lvl_q
);
  logic [PW-1:0] prev_q, wmask, wval, pol, edg, both, rise, fall, trig, clr;

  function automatic logic [PW-1:0] merge(input logic [PW-1:0] cur, input logic [PW-1:0] msk,
                                          input logic [PW-1:0] val, input logic [PW-1:0] guard);
    logic [PW-1:0] m;
    m = msk & ~guard;
    return (cur & ~m) | (val & m);
  endfunction

  always_comb begin
    wmask = alias_wr ? wdata[2*PW-1:PW] : '1;
    wval  = wdata[PW-1:0];
    pol   = lvl_q[PW-1:0];
    edg   = lvl_q[2*PW-1:PW];
    both  = lvl_q[3*PW-1:2*PW];
    rise  = pin_s & ~prev_q;
    fall  = ~pin_s & prev_q;
    trig  = (edg & both & (rise | fall))
          | (edg & ~both & ((pol & rise) | (~pol & fall)))
          | (~edg & ((pol & pin_s) | (~pol & ~pin_s)));
    clr   = (sel_wr && wtype == RT_CLR) ? (wval & wmask) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; lock_q <= '0; oe_q <= '0; out_q <= '0;
      en_q   <= '0; sts_q  <= '0; lvl_q <= '0; prev_q <= '0;
    end else begin
      prev_q <= pin_s;
      sts_q  <= (sts_q & ~clr) | (trig & en_q);
      if (sel_wr) begin
        case (wtype)
          RT_CFG: begin
            mode_q <= merge(mode_q, wmask, wval, lock_q);
            if (!alias_wr) lock_q <= lock_q | wdata[2*PW-1:PW];
          end
          RT_OE:  oe_q  <= merge(oe_q, wmask, wval, lock_q);
          RT_OUT: out_q <= merge(out_q, wmask, wval, lock_q);
          RT_EN:  en_q  <= merge(en_q, wmask, wval, '0);
          RT_LVL: begin
            if (alias_wr) lvl_q[PW-1:0] <= merge(lvl_q[PW-1:0], wmask, wval, '0);
            else          lvl_q         <= wdata;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS      = 2,
  parameter int PORTS_PER_BANK = 4,
  parameter int PINS_PER_PORT  = 8,
  localparam int PORT_W        = (PORTS_PER_BANK > 1) ? $clog2(PORTS_PER_BANK) : 1,
  localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W        = BANK_W + 1 + 3 + PORT_W,
  localparam int PINS_PER_BANK = PORTS_PER_BANK * PINS_PER_PORT,
  localparam int NUM_PINS      = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] spio_out,
  input  logic [NUM_PINS-1:0] spio_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_BANKS-1:0] irq
);
  localparam int PW        = PINS_PER_PORT;
  localparam int NUM_PORTS = NUM_BANKS * PORTS_PER_BANK;

  logic [PORT_W-1:0] a_port;
  logic [BANK_W-1:0] a_bank;
  logic              a_alias;
  reg_type_e         a_type;
  logic [NUM_PINS-1:0] pin_s, mode_all, lock_all, oe_all, out_all, en_all, sts_all;
  logic [3*NUM_PINS-1:0] lvl_all;
  logic [NUM_BANKS-1:0]  irq_d;
  logic [31:0]           rd_word;
  logic                  unused_wdata;

  assign unused_wdata = ^reg_wdata[31:3*PW];
  assign a_port  = reg_addr[PORT_W-1:0];
  assign a_type  = reg_type_e'(reg_addr[PORT_W +: 3]);
  assign a_alias = reg_addr[PORT_W+3];
  assign a_bank  = reg_addr[ADDR_W-1 -: BANK_W];

  gpio_sync #(.W(NUM_PINS)) u_sync (.clk(clk), .rst(rst), .d(pad_in), .q(pin_s));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar p = 0; p < PORTS_PER_BANK; p++) begin : g_port
      localparam int IDX = b * PORTS_PER_BANK + p;
      logic sel;
      assign sel = reg_wr && (a_bank == BANK_W'(b)) && (a_port == PORT_W'(p));
      gpio_port #(.PW(PW)) u_port (
        .clk(clk), .rst(rst), .sel_wr(sel), .alias_wr(a_alias), .wtype(a_type),
        .wdata(reg_wdata[3*PW-1:0]), .pin_s(pin_s[IDX*PW +: PW]),
        .mode_q(mode_all[IDX*PW +: PW]), .lock_q(lock_all[IDX*PW +: PW]),
        .oe_q(oe_all[IDX*PW +: PW]), .out_q(out_all[IDX*PW +: PW]),
        .en_q(en_all[IDX*PW +: PW]), .sts_q(sts_all[IDX*PW +: PW]),
        .lvl_q(lvl_all[IDX*3*PW +: 3*PW])
      );
    end
    assign irq_d[b] = |(sts_all[b*PINS_PER_BANK +: PINS_PER_BANK] & en_all[b*PINS_PER_BANK +: PINS_PER_BANK]);
  end

  always_comb begin
    int idx;
    idx = int'(a_bank) * PORTS_PER_BANK + int'(a_port);
    rd_word = '0;
    if (idx < NUM_PORTS) begin
      case (a_type)
        RT_CFG: rd_word = 32'({lock_all[idx*PW +: PW], mode_all[idx*PW +: PW]});
        RT_OE:  rd_word = 32'(oe_all[idx*PW +: PW]);
        RT_OUT: rd_word = 32'(out_all[idx*PW +: PW]);
        RT_IN:  rd_word = 32'(pin_s[idx*PW +: PW]);
        RT_STS: rd_word = 32'(sts_all[idx*PW +: PW]);
        RT_EN:  rd_word = 32'(en_all[idx*PW +: PW]);
        RT_LVL: rd_word = 32'(lvl_all[idx*3*PW +: 3*PW]);
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      pad_out   <= '0;
      pad_oe    <= '0;
      irq       <= '0;
    end else begin
      if (reg_rd) reg_rdata <= rd_word;
      pad_out <= (mode_all & out_all) | (~mode_all & spio_out);
      pad_oe  <= (mode_all & oe_all)  | (~mode_all & spio_oe);
      irq     <= irq_d;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS  = 64,
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_rd,
  input logic [31:0]          reg_rdata,
  input logic [NUM_PINS-1:0]  spio_oe,
  input logic [NUM_PINS-1:0]  spio_out,
  input logic [NUM_PINS-1:0]  pad_oe,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [NUM_BANKS-1:0] irq,
  input logic [NUM_PINS-1:0]  mode_all,
  input logic [NUM_PINS-1:0]  lock_all,
  input logic [NUM_PINS-1:0]  oe_all,
  input logic [NUM_PINS-1:0]  out_all,
  input logic [NUM_PINS-1:0]  en_all,
  input logic [NUM_PINS-1:0]  sts_all
);
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_rd)) |-> $stable(reg_rdata));

  p_pad_pass_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((((pad_oe ^ $past(spio_oe)) | (pad_out ^ $past(spio_out))) & ~$past(mode_all)) == '0));

  p_pad_drive_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((((pad_oe ^ $past(oe_all)) | (pad_out ^ $past(out_all))) & $past(mode_all)) == '0));

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lock_all & $past(lock_all)) == $past(lock_all)));

  p_locked_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((((mode_all ^ $past(mode_all)) | (oe_all ^ $past(oe_all)) |
                       (out_all ^ $past(out_all))) & $past(lock_all)) == '0));

  p_sts_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((sts_all & ~$past(sts_all) & ~$past(en_all)) == '0));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq != '0) |-> ($past(sts_all & en_all) != '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .spio_oe(spio_oe), .spio_out(spio_out), .pad_oe(pad_oe), .pad_out(pad_out),
  .irq(irq), .mode_all(mode_all), .lock_all(lock_all), .oe_all(oe_all),
  .out_all(out_all), .en_all(en_all), .sts_all(sts_all)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int NB = 2;
  localparam int NP = 64;
  localparam int AW = 7;
  localparam int T_CFG = 0, T_OE = 1, T_OUT = 2, T_IN = 3, T_STS = 4, T_EN = 5, T_LVL = 6, T_CLR = 7;

  logic clk = 0, rst = 1, reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] pad_in = '0, spio_out = '0, spio_oe = '0, pad_out, pad_oe;
  logic [NB-1:0] irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank_ctrl u0 (.clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in), .spio_out(spio_out),
    .spio_oe(spio_oe), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  function automatic logic [AW-1:0] mk(input int b, input int al, input int t, input int p);
    logic [AW-1:0] a;
    a = {b[0], al[0], t[2:0], p[1:0]};
    return a;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int b, input int al, input int t, input int p, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = mk(b, al, t, p); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int b, input int al, input int t, input int p, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = mk(b, al, t, p);
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    spio_oe = 64'h0123_4567_89AB_CDEF; spio_out = 64'hFEDC_BA98_7654_3210;
    cyc(2);
    check("R1 passthrough oe", pad_oe[31:0], 32'h89AB_CDEF);
    check("R1 passthrough out", pad_out[63:32], 32'hFEDC_BA98);
    rd(0, 0, T_CFG, 0, v); check("R1 cfg zero", v, 0);
    rd(1, 0, T_LVL, 3, v); check("R1 trigger zero", v, 0);
  endtask

  task automatic t_mode;
    logic [31:0] v;
    spio_out = '1; spio_oe = '1;
    wr(1, 0, T_CFG, 2, 32'h0F);
    wr(1, 0, T_OE, 2, 32'h03);
    wr(1, 0, T_OUT, 2, 32'h01);
    cyc(2);
    check("R3 gpio/spio oe mix", 32'(pad_oe[55:48]), 32'hF3);
    check("R3 gpio/spio out mix", 32'(pad_out[55:48]), 32'hF1);
    check("R3 neighbour port passthrough", 32'(pad_oe[47:40]), 32'hFF);
    rd(1, 1, T_OE, 2, v); check("R2 alias read", v, 32'h03);
    @(negedge clk); reg_rd = 0;
    cyc(1);
    check("R2 rdata holds", reg_rdata, 32'h03);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(0, 0, T_OE, 1, 32'h01);
    wr(0, 0, T_OUT, 1, 32'h01);
    wr(0, 0, T_CFG, 1, 32'h0101);
    wr(0, 0, T_CFG, 1, 32'h0000);
    rd(0, 0, T_CFG, 1, v); check("R4 lock and mode persist", v, 32'h0101);
    wr(0, 0, T_OE, 1, 32'h00);
    rd(0, 0, T_OE, 1, v); check("R5 locked oe ignored", v, 32'h01);
    wr(0, 0, T_OUT, 1, 32'hFE);
    rd(0, 0, T_OUT, 1, v); check("R5 locked out bit kept", v, 32'hFF);
    wr(0, 1, T_OE, 1, 32'hFF00);
    rd(0, 0, T_OE, 1, v); check("R5 alias blocked on locked pin", v, 32'h01);
    wr(0, 0, T_CFG, 1, 32'h0202);
    rd(0, 0, T_CFG, 1, v); check("R4 lock accumulates", v, 32'h0303);
    cyc(1);
    check("R5 locked pin drives", 32'(pad_out[8]), 1);
  endtask

  task automatic t_input;
    logic [31:0] v;
    pad_in[31:24] = 8'h5A;
    cyc(3);
    rd(0, 0, T_IN, 3, v); check("R6 input sample", v, 32'h5A);
    wr(0, 0, T_IN, 3, 32'hFF);
    rd(0, 0, T_IN, 3, v); check("R6 input write ignored", v, 32'h5A);
    wr(0, 0, T_STS, 3, 32'hFF);
    rd(0, 0, T_STS, 3, v); check("R6 status write ignored", v, 32'h00);
  endtask

  task automatic t_level;
    logic [31:0] v;
    pad_in[33:32] = 2'b10;
    wr(1, 0, T_LVL, 0, 32'h01);
    wr(1, 0, T_CLR, 0, 32'hFF);
    wr(1, 0, T_EN, 0, 32'h03);
    cyc(4);
    rd(1, 0, T_STS, 0, v); check("R7 inactive level", v, 0);
    pad_in[32] = 1; cyc(5);
    rd(1, 0, T_STS, 0, v); check("R7 high level sets", v, 32'h01);
    wr(1, 0, T_CLR, 0, 32'h01);
    rd(1, 0, T_STS, 0, v); check("R10 level re-asserts after clear", v, 32'h01);
    pad_in[32] = 0; cyc(4);
    wr(1, 0, T_CLR, 0, 32'h01);
    rd(1, 0, T_STS, 0, v); check("R10 clear after level gone", v, 0);
    pad_in[33] = 0; cyc(5);
    rd(1, 0, T_STS, 0, v); check("R7 low level sets", v, 32'h02);
    check("R11 bank irq high", 32'(irq[1]), 1);
    pad_in[33] = 1; cyc(4);
    wr(1, 0, T_CLR, 0, 32'h02);
    cyc(2);
    check("R11 bank irq low", 32'(irq[1]), 0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    pad_in[17:16] = 2'b10; cyc(4);
    wr(0, 0, T_LVL, 2, 32'h0301);
    wr(0, 0, T_CLR, 2, 32'hFF);
    wr(0, 0, T_EN, 2, 32'h03);
    cyc(3);
    rd(0, 0, T_STS, 2, v); check("R8 no edge no status", v, 0);
    pad_in[16] = 1; cyc(5);
    rd(0, 0, T_STS, 2, v); check("R8 rising edge", v, 32'h01);
    pad_in[17] = 0; cyc(5);
    rd(0, 0, T_STS, 2, v); check("R8 falling edge", v, 32'h03);
    wr(0, 0, T_CLR, 2, 32'h03);
    rd(0, 0, T_STS, 2, v); check("R10 edge status cleared", v, 0);
    pad_in[16] = 0; cyc(5);
    rd(0, 0, T_STS, 2, v); check("R8 wrong edge ignored", v, 0);
  endtask

  task automatic t_either;
    logic [31:0] v;
    wr(1, 0, T_LVL, 3, 32'h01_0100);
    wr(1, 0, T_CLR, 3, 32'hFF);
    wr(1, 0, T_EN, 3, 32'h01);
    pad_in[56] = 1; cyc(5);
    rd(1, 0, T_STS, 3, v); check("R9 either edge rise", v, 32'h01);
    wr(1, 0, T_CLR, 3, 32'h01);
    rd(1, 0, T_STS, 3, v); check("R9 cleared", v, 0);
    pad_in[56] = 0; cyc(5);
    rd(1, 0, T_STS, 3, v); check("R9 either edge fall", v, 32'h01);
    wr(1, 0, T_CLR, 3, 32'h01);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    cyc(3);
    rd(0, 0, T_STS, 0, v); check("R11 disabled never latches", v, 0);
    check("R11 irq idle", 32'(irq[0]), 0);
    wr(0, 1, T_EN, 0, 32'h0101);
    cyc(3);
    rd(0, 0, T_STS, 0, v); check("R11 enabled level-low latches", v, 32'h01);
    check("R11 irq raised", 32'(irq[0]), 1);
    wr(0, 0, T_EN, 0, 32'h00);
    cyc(2);
    check("R11 irq masked by enable", 32'(irq[0]), 0);
    rd(0, 0, T_STS, 0, v); check("R11 status kept when disabled", v, 32'h01);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    wr(0, 0, T_OUT, 0, 32'hF0);
    wr(0, 1, T_OUT, 0, 32'h3C24);
    rd(0, 0, T_OUT, 0, v); check("R12 masked update", v, 32'hE4);
    wr(0, 1, T_CFG, 0, 32'hFFFF);
    rd(0, 0, T_CFG, 0, v); check("R12 alias cannot lock", v, 32'h00FF);
    wr(0, 1, T_CLR, 0, 32'h0100);
    rd(0, 0, T_STS, 0, v); check("R12 clear data 0 no effect", v, 32'h01);
    wr(0, 1, T_CLR, 0, 32'h0101);
    rd(0, 0, T_STS, 0, v); check("R12 alias clear", v, 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst = 0;
    t_reset;
    t_mode;
    t_lock;
    t_input;
    t_level;
    t_edge;
    t_either;
    t_gate;
    t_alias;
    done = 1;
    finish_run;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run;
    end
  end
endmodule